// File: doc/BRIEF.md
# Load-Use Stall and Branch Flush Controller

This block decides, within a single cycle, whether the front of a five-stage in-order pipeline must pause or discard work. It looks at the instruction currently in the execute stage and at the instruction sitting in decode. When a memory load in execute writes a register that the decode instruction reads, it freezes the program counter and the fetch/decode register for one cycle and sends an all-zero control word (a bubble) into execute. When a branch resolved in decode is taken, it discards the instruction fetched behind it. If both situations arise in the same cycle, the pause takes precedence, and the branch is looked at again on the next cycle.

The decision logic is purely combinational. A small clocked set of pipeline registers is wrapped around it: a program counter, a fetch/decode register and a decode/execute register. These let the pause, the bubble and the discard be seen at the ports. Forwarding, the arithmetic datapath, branch targets and prediction are not part of the block. The program counter simply advances by a fixed step whenever writing is allowed.

Top module: `hz_unit`

## Requirements
- R1: A pause (`ctrl_zero`=1) is raised when the execute instruction has its load bit set, its destination is nonzero, and the destination equals the first source of the decode instruction. Without the load bit there is never a pause.
- R2: A match on the second source alone also raises a pause. An example is a store whose data register is the loaded register.
- R3: A destination register of 0 in execute never raises a pause, whatever the decode sources are.
- R4: During a pause, `pc_we`=0 and `ifid_we`=0. On the next cycle `pc` and every decode-stage output equal their values in the pausing cycle.
- R5: In the cycle after a pause, the execute-stage control bits `ex_valid`, `ex_mem_read`, `ex_reg_write` and `ex_branch` are all 0. They are forced to zero, not held.
- R6: One load-use match gives exactly one bubble cycle, even when both sources match. A pause is never followed by a pause caused by the same load.
- R7: The pause and discard outputs respond in the same cycle as the register state and `dec_br_taken` that cause them. No clock edge lies between cause and response.
- R8: `ifid_flush`=1 only when the decode instruction is a branch and `dec_br_taken`=1. On the next cycle the decode stage is empty (`dec_valid`=0) and `pc` has advanced. A not-taken branch causes no discard and no bubble.
- R9: A load whose destination is read by neither source of the next instruction causes no pause and no lost cycle.
- R10: When a pause and a taken branch in decode occur together, the pause wins: `ifid_flush`=0 in that cycle. The discard is raised on the following cycle, with the branch still in decode.
- R11: After reset, `pc`=0 and the decode and execute stages are empty. With no condition active, `pc_we`=1, `ifid_we`=1, `ctrl_zero`=0 and `ifid_flush`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Fetched instruction is real |
| fetch_mem_read | input | 1 | Fetched instruction is a load |
| fetch_reg_write | input | 1 | Fetched instruction writes a register |
| fetch_branch | input | 1 | Fetched instruction is a branch |
| fetch_rd | input | 5 | Destination register of fetched instruction |
| fetch_rs | input | 5 | First source of fetched instruction |
| fetch_rt | input | 5 | Second source of fetched instruction |
| dec_br_taken | input | 1 | Branch outcome for the instruction in decode |
| pc | output | 32 | Program counter |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| ctrl_zero | output | 1 | Force execute control bits to zero (pause) |
| ifid_flush | output | 1 | Discard the fetched instruction |
| dec_valid | output | 1 | Decode stage holds a real instruction |
| dec_branch | output | 1 | Decode instruction is a branch |
| dec_rs | output | 5 | First source in decode |
| dec_rt | output | 5 | Second source in decode |
| ex_valid | output | 1 | Execute control: valid |
| ex_mem_read | output | 1 | Execute control: load |
| ex_reg_write | output | 1 | Execute control: register write |
| ex_branch | output | 1 | Execute control: branch |
| ex_rd | output | 5 | Destination register in execute |

## Verification
A pause and a branch discard can both be requested in the same cycle. The bench provokes this by placing a taken branch that reads a freshly loaded register directly after the load. A reference model must then see the discard suppressed in the pausing cycle, and raised on the following cycle with the program counter held once. The final tally of bubbles and discards over the whole program is compared against the count expected from the program.

// File: rtl/hz_pkg.sv
package hz_pkg;
    parameter int REG_W   = 5;
    parameter int NUM_SRC = 2;

    typedef logic [REG_W-1:0] reg_idx_t;

    typedef struct packed {
        logic valid;
        logic mem_read;
        logic reg_write;
        logic branch;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        ctrl_t    ctrl;
        reg_idx_t rd;
        reg_idx_t rs;
        reg_idx_t rt;
    } instr_t;

    localparam instr_t INSTR_NOP = '0;

    function automatic logic reg_is_live(reg_idx_t r);
        return r != '0;
    endfunction

    function automatic ctrl_t squash(ctrl_t c, logic kill);
        return kill ? ctrl_t'('0) : c;
    endfunction
endpackage

// File: rtl/hz_detect.sv
module hz_detect
    import hz_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ex_mem_read,
    input  reg_idx_t ex_rd,
    input  reg_idx_t src [NUM_SRC],
    input  logic     dec_branch,
    input  logic     dec_taken,
    output logic     stall,
    output logic     flush,
    output logic     pc_we,
    output logic     ifid_we
);
    logic [NUM_SRC-1:0] src_hit;

    // one comparator per decode source operand
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_cmp
        assign src_hit[i] = (src[i] == ex_rd);
    end

    always_comb begin
        stall   = ex_mem_read && reg_is_live(ex_rd) && (|src_hit);
        flush   = dec_branch && dec_taken && !stall;
        pc_we   = !stall;
        ifid_we = !stall;
    end

    assert_zero_dest_R3: assert property (@(posedge clk) disable iff (rst)
        (ex_rd == '0) |-> !stall);

    assert_load_only_R1: assert property (@(posedge clk) disable iff (rst)
        !ex_mem_read |-> !stall);

    assert_flush_cause_R8: assert property (@(posedge clk) disable iff (rst)
        flush |-> (dec_branch && dec_taken));
endmodule

// File: rtl/hz_ctrl_mux.sv
module hz_ctrl_mux
    import hz_pkg::*;
(
    input  ctrl_t ctrl_in,
    input  logic  zero_sel,
    output ctrl_t ctrl_out
);
    always_comb ctrl_out = squash(ctrl_in, zero_sel);
endmodule

// File: rtl/hz_pipe_regs.sv
module hz_pipe_regs
    import hz_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int PC_STEP = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pc_we,
    input  logic            ifid_we,
    input  logic            ifid_flush,
    input  instr_t          fetch_in,
    input  ctrl_t           idex_ctrl_d,
    output logic [PC_W-1:0] pc_q,
    output instr_t          ifid_q,
    output instr_t          idex_q
);
    localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            ifid_q <= INSTR_NOP;
            idex_q <= INSTR_NOP;
        end else begin
            if (pc_we)
                pc_q <= pc_q + STEP;
            if (ifid_we)
                ifid_q <= ifid_flush ? INSTR_NOP : fetch_in;
            idex_q.ctrl <= idex_ctrl_d;
            idex_q.rd   <= ifid_q.rd;
            idex_q.rs   <= ifid_q.rs;
            idex_q.rt   <= ifid_q.rt;
        end
    end

    assert_pc_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !pc_we |=> (pc_q == $past(pc_q)));

    assert_ifid_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !ifid_we |=> (ifid_q == $past(ifid_q)));
endmodule

// File: rtl/hz_unit.sv
module hz_unit
    import hz_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int PC_STEP = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fetch_valid,
    input  logic            fetch_mem_read,
    input  logic            fetch_reg_write,
    input  logic            fetch_branch,
    input  logic [4:0]      fetch_rd,
    input  logic [4:0]      fetch_rs,
    input  logic [4:0]      fetch_rt,
    input  logic            dec_br_taken,
    output logic [PC_W-1:0] pc,
    output logic            pc_we,
    output logic            ifid_we,
    output logic            ctrl_zero,
    output logic            ifid_flush,
    output logic            dec_valid,
    output logic            dec_branch,
    output logic [4:0]      dec_rs,
    output logic [4:0]      dec_rt,
    output logic            ex_valid,
    output logic            ex_mem_read,
    output logic            ex_reg_write,
    output logic            ex_branch,
    output logic [4:0]      ex_rd
);
    instr_t   fetch_i;
    instr_t   ifid_q;
    instr_t   idex_q;
    ctrl_t    idex_ctrl_d;
    reg_idx_t dec_src [NUM_SRC];
    logic     stall;
    logic     flush;

    always_comb begin
        fetch_i.ctrl.valid     = fetch_valid;
        fetch_i.ctrl.mem_read  = fetch_mem_read;
        fetch_i.ctrl.reg_write = fetch_reg_write;
        fetch_i.ctrl.branch    = fetch_branch;
        fetch_i.rd             = fetch_rd;
        fetch_i.rs             = fetch_rs;
        fetch_i.rt             = fetch_rt;
    end

    assign dec_src[0] = ifid_q.rs;
    assign dec_src[1] = ifid_q.rt;

    hz_detect u_detect (
        .clk         (clk),
        .rst         (rst),
        .ex_mem_read (idex_q.ctrl.mem_read),
        .ex_rd       (idex_q.rd),
        .src         (dec_src),
        .dec_branch  (ifid_q.ctrl.branch),
        .dec_taken   (dec_br_taken),
        .stall       (stall),
        .flush       (flush),
        .pc_we       (pc_we),
        .ifid_we     (ifid_we)
    );

    hz_ctrl_mux u_mux (
        .ctrl_in  (ifid_q.ctrl),
        .zero_sel (stall),
        .ctrl_out (idex_ctrl_d)
    );

    hz_pipe_regs #(.PC_W(PC_W), .PC_STEP(PC_STEP)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .pc_we       (pc_we),
        .ifid_we     (ifid_we),
        .ifid_flush  (flush),
        .fetch_in    (fetch_i),
        .idex_ctrl_d (idex_ctrl_d),
        .pc_q        (pc),
        .ifid_q      (ifid_q),
        .idex_q      (idex_q)
    );

    assign ctrl_zero    = stall;
    assign ifid_flush   = flush;
    assign dec_valid    = ifid_q.ctrl.valid;
    assign dec_branch   = ifid_q.ctrl.branch;
    assign dec_rs       = ifid_q.rs;
    assign dec_rt       = ifid_q.rt;
    assign ex_valid     = idex_q.ctrl.valid;
    assign ex_mem_read  = idex_q.ctrl.mem_read;
    assign ex_reg_write = idex_q.ctrl.reg_write;
    assign ex_branch    = idex_q.ctrl.branch;
    assign ex_rd        = idex_q.rd;

    assert_bubble_zero_R5: assert property (@(posedge clk) disable iff (rst)
        ctrl_zero |=> (!ex_valid && !ex_mem_read && !ex_reg_write && !ex_branch));

    assert_single_bubble_R6: assert property (@(posedge clk) disable iff (rst)
        ctrl_zero |=> !ctrl_zero);

    assert_pause_wins_R10: assert property (@(posedge clk) disable iff (rst)
        ctrl_zero |-> (!ifid_flush && !ifid_we));

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (rst)
        ifid_flush |=> (!dec_valid && (pc != $past(pc))));
endmodule

// File: tb/tb_hz_unit.sv
module tb_hz_unit;
    localparam int NPROG = 32;
    localparam int RUN_CYCLES = 34;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        fetch_valid = 0, fetch_mem_read = 0, fetch_reg_write = 0, fetch_branch = 0;
    logic [4:0]  fetch_rd = 0, fetch_rs = 0, fetch_rt = 0;
    logic        dec_br_taken = 0;
    logic [31:0] pc;
    logic        pc_we, ifid_we, ctrl_zero, ifid_flush;
    logic        dec_valid, dec_branch, ex_valid, ex_mem_read, ex_reg_write, ex_branch;
    logic [4:0]  dec_rs, dec_rt, ex_rd;

    hz_unit dut (.*);

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // program memory, one entry per word address
    int p_val [NPROG], p_ld [NPROG], p_wr [NPROG], p_br [NPROG], p_tk [NPROG];
    int p_rd [NPROG], p_rs [NPROG], p_rt [NPROG];

    // reference model state
    int m_pc, m_dec;
    int mx_val, mx_ld, mx_wr, mx_br, mx_rd;
    int bubbles_seen, flushes_seen;

    task automatic chk(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d pc=%0d t=%0t", tag, act, exp, m_pc, $time);
        end
    endtask

    task automatic put(int i, int v, int ld, int wr, int br, int tk, int rd, int rs, int rt);
        p_val[i] = v; p_ld[i] = ld; p_wr[i] = wr; p_br[i] = br; p_tk[i] = tk;
        p_rd[i] = rd; p_rs[i] = rs; p_rt[i] = rt;
    endtask

    function automatic int fld(int idx, int which);
        if (idx < 0 || idx >= NPROG) return 0;
        case (which)
            0: return p_val[idx];
            1: return p_ld[idx];
            2: return p_wr[idx];
            3: return p_br[idx];
            4: return p_tk[idx];
            5: return p_rd[idx];
            6: return p_rs[idx];
            default: return p_rt[idx];
        endcase
    endfunction

    function automatic string pause_tag(int exp_stall);
        if (mx_ld != 0 && mx_rd == 0) return "R3";
        if (exp_stall != 0 && mx_rd != fld(m_dec, 6)) return "R2";
        if (mx_ld != 0 && exp_stall == 0) return "R9";
        return "R1";
    endfunction

    initial begin
        for (int i = 0; i < NPROG; i++) put(i, 0, 0, 0, 0, 0, 0, 0, 0);
        //        v ld wr br tk rd rs rt
        put(0,  1, 1, 1, 0, 0, 5, 1, 0);   // load r5
        put(1,  1, 0, 1, 0, 0, 3, 5, 2);   // uses r5 as first source
        put(2,  1, 0, 1, 0, 0, 7, 1, 1);
        put(3,  1, 1, 1, 0, 0, 6, 1, 0);   // load r6
        put(4,  1, 0, 1, 0, 0, 4, 3, 4);   // independent
        put(5,  1, 1, 1, 0, 0, 0, 1, 0);   // load into r0
        put(6,  1, 0, 1, 0, 0, 2, 0, 0);   // reads r0
        put(7,  1, 1, 1, 0, 0, 8, 1, 0);   // load r8
        put(8,  1, 0, 0, 0, 0, 0, 1, 8);   // store data r8 (second source)
        put(9,  1, 1, 1, 0, 0, 9, 2, 0);   // load r9
        put(10, 1, 0, 1, 0, 0, 11, 9, 9);  // both sources r9
        put(11, 1, 0, 0, 1, 1, 0, 1, 2);   // taken branch
        put(12, 1, 0, 1, 0, 0, 12, 1, 1);  // wrong path
        put(13, 1, 0, 0, 1, 0, 0, 3, 4);   // not-taken branch
        put(14, 1, 0, 1, 0, 0, 13, 2, 3);
        put(15, 1, 1, 1, 0, 0, 10, 1, 0);  // load r10
        put(16, 1, 0, 0, 1, 1, 0, 10, 1);  // taken branch reading r10
        put(17, 1, 0, 1, 0, 0, 14, 1, 1);  // wrong path

        m_pc = 0; m_dec = -1;
        mx_val = 0; mx_ld = 0; mx_wr = 0; mx_br = 0; mx_rd = 0;
        bubbles_seen = 0; flushes_seen = 0;

        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // reset state and idle defaults
        chk("R11 pc", int'(pc), 0);
        chk("R11 dec_valid", int'(dec_valid), 0);
        chk("R11 ex_valid", int'(ex_valid), 0);
        chk("R11 pc_we", int'(pc_we), 1);
        chk("R11 ifid_we", int'(ifid_we), 1);
        chk("R11 ctrl_zero", int'(ctrl_zero), 0);
        chk("R11 ifid_flush", int'(ifid_flush), 0);

        for (int c = 0; c < RUN_CYCLES; c++) begin
            int fi, e_stall, e_flush;
            if (c != 0) @(negedge clk);
            // registered outputs
            chk("R4 pc", int'(pc), m_pc);
            chk("R4 dec_valid", int'(dec_valid), fld(m_dec, 0));
            chk("R4 dec_branch", int'(dec_branch), fld(m_dec, 3));
            chk("R4 dec_rs", int'(dec_rs), fld(m_dec, 6));
            chk("R4 dec_rt", int'(dec_rt), fld(m_dec, 7));
            chk("R5 ex_valid", int'(ex_valid), mx_val);
            chk("R5 ex_mem_read", int'(ex_mem_read), mx_ld);
            chk("R5 ex_reg_write", int'(ex_reg_write), mx_wr);
            chk("R5 ex_branch", int'(ex_branch), mx_br);
            chk("R5 ex_rd", int'(ex_rd), mx_rd);

            // drive this cycle's inputs
            fi = m_pc / 4;
            fetch_valid     = fld(fi, 0) != 0;
            fetch_mem_read  = fld(fi, 1) != 0;
            fetch_reg_write = fld(fi, 2) != 0;
            fetch_branch    = fld(fi, 3) != 0;
            fetch_rd        = 5'(fld(fi, 5));
            fetch_rs        = 5'(fld(fi, 6));
            fetch_rt        = 5'(fld(fi, 7));
            dec_br_taken    = fld(m_dec, 4) != 0;
            #1;

            e_stall = (mx_ld != 0 && mx_rd != 0 &&
                       (mx_rd == fld(m_dec, 6) || mx_rd == fld(m_dec, 7))) ? 1 : 0;
            e_flush = (e_stall == 0 && fld(m_dec, 3) != 0 && fld(m_dec, 4) != 0) ? 1 : 0;

            chk(pause_tag(e_stall), int'(ctrl_zero), e_stall);
            chk("R4,R7 pc_we", int'(pc_we), 1 - e_stall);
            chk("R4,R7 ifid_we", int'(ifid_we), 1 - e_stall);
            if (e_stall != 0 && fld(m_dec, 3) != 0 && fld(m_dec, 4) != 0)
                chk("R10 ifid_flush", int'(ifid_flush), 0);
            else
                chk("R8 ifid_flush", int'(ifid_flush), e_flush);

            if (ctrl_zero) bubbles_seen++;
            if (ifid_flush) flushes_seen++;

            // model advance for the coming edge
            if (e_stall != 0) begin
                mx_val = 0; mx_ld = 0; mx_wr = 0; mx_br = 0;
                mx_rd = fld(m_dec, 5);
            end else begin
                mx_val = fld(m_dec, 0); mx_ld = fld(m_dec, 1);
                mx_wr = fld(m_dec, 2);  mx_br = fld(m_dec, 3);
                mx_rd = fld(m_dec, 5);
                m_dec = (e_flush != 0) ? -1 : fi;
                m_pc  = m_pc + 4;
            end
        end

        // loads at 0,7,9,15 have consumers: four single bubbles; two taken branches
        chk("R6 bubble count", bubbles_seen, 4);
        chk("R8 flush count", flushes_seen, 2);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(8 * 5000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule